// File: doc/BRIEF.md
# Auxiliary Channel Request/Reply Engine

This block runs one half-duplex request/reply exchange on a display auxiliary channel. Software sees a word-wide register window: one control/status word and five data words, 20 bytes in all. The data words hold the request on the way out and the reply on the way back. Bytes sit big-endian inside each word, so buffer byte 0 is bits 31:24 of data word 0. To start an exchange, software loads the request bytes and writes the control word with the busy bit, a byte count and the timing settings. The engine then sends a run of low precharge pulses, a run of high preamble pulses and the request bytes, MSB first, on a bit stream toward a line driver.

After the last request bit the engine releases the line and waits for a reply bit stream from the line receiver. It packs the reply bytes into the buffer and writes the reply byte count back into the count field. It raises sticky done and error flags, and software clears each flag by writing a 1 to it. A watchdog counted in bit periods ends an exchange that gets no reply. The bit period is a programmable number of clock cycles. To get about 2 MHz, software sets the divider to the clock frequency in kHz divided by 2000, rounded.

Top module: `aux_xact_engine`

## Requirements
- R1: After reset the control word and all five data words read 0, and tx_oe_o, tx_stb_o and tx_bit_o are low.
- R2: Writing the control word (address 0) with bit 31 set and a count (bits 24:20) of 1 to 20 while idle starts an exchange. Bit 31 then reads 1 until the exchange ends by reply or by timeout, and the count field does not change while busy.
- R3: Every transmitted bit comes with a one-cycle tx_stb_o. The exchange opens with precharge pulses (bit 0) and then preamble pulses (bit 1). The counts are 16 and 16 when bit 27 is 0 (normal), and 10 and 8 when bit 27 is 1 (fast wake).
- R4: After the sync run, the engine sends the number of request bytes given by the count field, in buffer order and MSB first. Byte k is read from data word k/4 (address k/4+1) at bits 31-8*(k%4) down to 24-8*(k%4).
- R5: Consecutive tx_stb_o pulses are exactly D clock cycles apart, where D is bits 10:0 of the control word. D = 0 acts as 1.
- R6: A reply is a run of rx_valid_i bits, MSB first, with rx_last_i marking the final one. Reply byte j is stored big-endian into buffer byte j. At the end, busy clears, done (bit 30) sets and the count field holds the number of whole reply bytes received, saturating at 31.
- R7: Buffer bytes beyond the reply length keep their previous contents.
- R8: A reply with 0 whole bytes, more than 20 bytes, or a trailing partial byte sets receive-error (bit 28) together with done. Reply bytes past the 20th are not stored.
- R9: If no reply bit arrives within the timeout, busy clears and done and timeout-error (bit 29) set. The timeout is 800 bit periods when bit 26 is 0 and 1200 bit periods when bit 26 is 1, counted from the end of transmission or from the latest reply bit.
- R10: Writing 1 to bit 30, 29 or 28 of the control word clears that flag. Writing 0 leaves it unchanged.
- R11: While busy, writes to the data words and to the control word are ignored.
- R12: A start request with a count of 0 or above 20 does not start an exchange. Busy stays 0, the line stays idle and receive-error sets.
- R13: tx_oe_o is high only while busy, and it falls one bit period after the last request bit.

Top module port list follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 3 | Register word address: 0 control, 1..5 data |
| we_i | input | 1 | Register write strobe |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Register read data for addr_i (combinational) |
| tx_bit_o | output | 1 | Serial bit toward the line driver |
| tx_oe_o | output | 1 | Line driver enable |
| tx_stb_o | output | 1 | Marks the first cycle of each transmitted bit |
| rx_valid_i | input | 1 | A received bit is present this cycle |
| rx_bit_i | input | 1 | Received bit value |
| rx_last_i | input | 1 | Marks the final bit of the reply |

## Verification
A wrong serializer phase counter shows up within one exchange as a sync run of the wrong length or as shifted request bits on tx_bit_o. A wrong reply byte index or a wrong saturation value shows up when the control and data words are read back right after busy clears. A broken bit-period divider or timeout counter shifts the spacing of tx_stb_o, or the cycle on which busy falls when no reply comes, by a whole number of bit periods. Busy-time write protection is checked by writing during an exchange and then reading back the data word just past a short reply.

// File: rtl/aux_xact_pkg.sv
package aux_xact_pkg;
  localparam int unsigned DATA_WORDS = 5;
  localparam int unsigned MAX_BYTES  = DATA_WORDS * 4;
  localparam int unsigned SIZE_W     = 5;
  localparam int unsigned IDX_W      = 5;
  localparam int unsigned ADDR_W     = $clog2(DATA_WORDS + 1);

  // control word layout
  localparam int unsigned BIT_BUSY   = 31;
  localparam int unsigned BIT_DONE   = 30;
  localparam int unsigned BIT_TOERR  = 29;
  localparam int unsigned BIT_RXERR  = 28;
  localparam int unsigned BIT_FAST   = 27;
  localparam int unsigned BIT_TOLONG = 26;
  localparam int unsigned SIZE_LSB   = 20;

  typedef enum logic [1:0] {ENG_IDLE, ENG_TX, ENG_WAIT} eng_state_e;
  typedef enum logic [2:0] {SER_IDLE, SER_PRE, SER_AMB, SER_DATA, SER_END} ser_phase_e;
endpackage

// File: rtl/aux_bit_tick.sv
module aux_bit_tick #(
  parameter int unsigned DIV_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] last;

  assign last   = (div_i == '0) ? '0 : div_i - 1'b1;
  assign tick_o = en_i && (cnt_q == last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (!en_i || tick_o)  cnt_q <= '0;
    else                       cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/aux_tx_shift.sv
module aux_tx_shift
  import aux_xact_pkg::*;
#(
  parameter int unsigned PRE_NORMAL = 16,
  parameter int unsigned AMB_NORMAL = 16,
  parameter int unsigned PRE_FAST   = 10,
  parameter int unsigned AMB_FAST   = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             fast_i,
  input  logic [SIZE_W-1:0] nbytes_i,
  input  logic             tick_i,
  input  logic [7:0]       byte_i,
  output logic [IDX_W-1:0] byte_idx_o,
  output logic             bit_o,
  output logic             oe_o,
  output logic             stb_o,
  output logic             done_o
);
  localparam int unsigned MAX_A = (PRE_NORMAL > AMB_NORMAL) ? PRE_NORMAL : AMB_NORMAL;
  localparam int unsigned MAX_B = (PRE_FAST > AMB_FAST) ? PRE_FAST : AMB_FAST;
  localparam int unsigned MAX_P = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int unsigned CNT_W = $clog2(MAX_P + 1);

  ser_phase_e       phase_q;
  logic [CNT_W-1:0] cnt_q;
  logic [IDX_W-1:0] idx_q;
  logic [2:0]       pos_q;
  logic [CNT_W-1:0] pre_len, amb_len;

  assign pre_len    = fast_i ? CNT_W'(PRE_FAST) : CNT_W'(PRE_NORMAL);
  assign amb_len    = fast_i ? CNT_W'(AMB_FAST) : CNT_W'(AMB_NORMAL);
  assign byte_idx_o = idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= SER_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      pos_q   <= 3'd7;
      bit_o   <= 1'b0;
      oe_o    <= 1'b0;
      stb_o   <= 1'b0;
      done_o  <= 1'b0;
    end else begin
      stb_o  <= 1'b0;
      done_o <= 1'b0;
      unique case (phase_q)
        SER_IDLE: if (start_i) begin
          phase_q <= SER_PRE;
          cnt_q   <= '0;
          idx_q   <= '0;
          pos_q   <= 3'd7;
          oe_o    <= 1'b1;
        end
        SER_PRE: if (tick_i) begin
          bit_o <= 1'b0;
          stb_o <= 1'b1;
          if (cnt_q == pre_len - 1'b1) begin
            phase_q <= SER_AMB;
            cnt_q   <= '0;
          end else cnt_q <= cnt_q + 1'b1;
        end
        SER_AMB: if (tick_i) begin
          bit_o <= 1'b1;
          stb_o <= 1'b1;
          if (cnt_q == amb_len - 1'b1) begin
            phase_q <= SER_DATA;
            cnt_q   <= '0;
          end else cnt_q <= cnt_q + 1'b1;
        end
        SER_DATA: if (tick_i) begin
          bit_o <= byte_i[pos_q];
          stb_o <= 1'b1;
          pos_q <= pos_q - 1'b1;
          if (pos_q == 3'd0) begin
            if (idx_q == IDX_W'(nbytes_i) - 1'b1) phase_q <= SER_END;
            else                                  idx_q   <= idx_q + 1'b1;
          end
        end
        SER_END: if (tick_i) begin
          oe_o    <= 1'b0;
          bit_o   <= 1'b0;
          done_o  <= 1'b1;
          phase_q <= SER_IDLE;
        end
        default: phase_q <= SER_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/aux_rx_shift.sv
module aux_rx_shift
  import aux_xact_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              clear_i,
  input  logic              valid_i,
  input  logic              bit_i,
  input  logic              last_i,
  output logic              byte_stb_o,
  output logic [7:0]        byte_o,
  output logic [IDX_W-1:0]  byte_idx_o,
  output logic              end_o,
  output logic [SIZE_W-1:0] count_o,
  output logic              partial_o
);
  logic [6:0] sh_q;
  logic [2:0] nb_q;
  logic       take;

  assign take = en_i && valid_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q       <= '0;
      nb_q       <= '0;
      byte_stb_o <= 1'b0;
      byte_o     <= '0;
      byte_idx_o <= '0;
      end_o      <= 1'b0;
      count_o    <= '0;
      partial_o  <= 1'b0;
    end else begin
      byte_stb_o <= 1'b0;
      end_o      <= 1'b0;
      if (clear_i) begin
        nb_q      <= '0;
        count_o   <= '0;
        partial_o <= 1'b0;
      end else if (take) begin
        sh_q <= {sh_q[5:0], bit_i};
        nb_q <= nb_q + 1'b1;
        if (nb_q == 3'd7) begin
          byte_stb_o <= 1'b1;
          byte_o     <= {sh_q, bit_i};
          byte_idx_o <= IDX_W'(count_o);
          if (count_o != '1) count_o <= count_o + 1'b1;
        end
        if (last_i) begin
          end_o     <= 1'b1;
          partial_o <= (nb_q != 3'd7);
        end
      end
    end
  end
endmodule

// File: rtl/aux_xact_engine.sv
module aux_xact_engine
  import aux_xact_pkg::*;
#(
  parameter int unsigned DIV_W          = 11,
  parameter int unsigned TO_SHORT_TICKS = 800,
  parameter int unsigned TO_LONG_TICKS  = 1200,
  parameter int unsigned PRE_NORMAL     = 16,
  parameter int unsigned AMB_NORMAL     = 16,
  parameter int unsigned PRE_FAST       = 10,
  parameter int unsigned AMB_FAST       = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              tx_bit_o,
  output logic              tx_oe_o,
  output logic              tx_stb_o,
  input  logic              rx_valid_i,
  input  logic              rx_bit_i,
  input  logic              rx_last_i
);
  localparam int unsigned TO_MAX = (TO_LONG_TICKS > TO_SHORT_TICKS) ? TO_LONG_TICKS : TO_SHORT_TICKS;
  localparam int unsigned TO_W   = $clog2(TO_MAX + 1);

  eng_state_e        state_q;
  logic              busy;
  logic              done_q, to_err_q, rx_err_q, fast_q, tolong_q;
  logic [SIZE_W-1:0] size_q;
  logic [DIV_W-1:0]  div_q;
  logic [TO_W-1:0]   tcnt_q;
  logic [7:0]        buf_q [MAX_BYTES];

  logic              ctrl_wr, data_wr, start, reject, size_ok;
  logic [SIZE_W-1:0] req_size;
  logic              tick, ser_done;
  logic [IDX_W-1:0]  ser_idx;
  logic [7:0]        ser_byte;
  logic              rx_stb, rx_end, rx_partial;
  logic [7:0]        rx_byte;
  logic [IDX_W-1:0]  rx_idx;
  logic [SIZE_W-1:0] rx_count;
  logic [TO_W-1:0]   to_limit;
  logic              timeout_hit, reply_bad;
  logic              wdata_unused;

  assign busy     = (state_q != ENG_IDLE);
  assign req_size = wdata_i[SIZE_LSB +: SIZE_W];
  assign size_ok  = (req_size != '0) && (req_size <= SIZE_W'(MAX_BYTES));
  assign ctrl_wr  = we_i && (addr_i == '0) && !busy;
  assign data_wr  = we_i && (addr_i != '0) && (addr_i <= ADDR_W'(DATA_WORDS)) && !busy;
  assign start    = ctrl_wr && wdata_i[BIT_BUSY] && size_ok;
  assign reject   = ctrl_wr && wdata_i[BIT_BUSY] && !size_ok;
  assign wdata_unused = ^{wdata_i[25], wdata_i[SIZE_LSB-1:DIV_W]};

  assign to_limit    = tolong_q ? TO_W'(TO_LONG_TICKS) : TO_W'(TO_SHORT_TICKS);
  assign timeout_hit = (state_q == ENG_WAIT) && tick && !rx_valid_i && (tcnt_q == to_limit - 1'b1);
  assign reply_bad   = rx_partial || (rx_count == '0) || (rx_count > SIZE_W'(MAX_BYTES));

  aux_bit_tick #(.DIV_W(DIV_W)) u_tick (
    .clk_i (clk_i), .rst_ni(rst_ni), .en_i(busy), .div_i(div_q), .tick_o(tick)
  );

  always_comb begin
    ser_byte = '0;
    for (int k = 0; k < MAX_BYTES; k++)
      if (ser_idx == IDX_W'(k)) ser_byte = buf_q[k];
  end

  aux_tx_shift #(
    .PRE_NORMAL(PRE_NORMAL), .AMB_NORMAL(AMB_NORMAL),
    .PRE_FAST(PRE_FAST), .AMB_FAST(AMB_FAST)
  ) u_tx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .fast_i    (fast_q),
    .nbytes_i  (size_q),
    .tick_i    (tick),
    .byte_i    (ser_byte),
    .byte_idx_o(ser_idx),
    .bit_o     (tx_bit_o),
    .oe_o      (tx_oe_o),
    .stb_o     (tx_stb_o),
    .done_o    (ser_done)
  );

  aux_rx_shift u_rx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (state_q == ENG_WAIT),
    .clear_i   (start),
    .valid_i   (rx_valid_i),
    .bit_i     (rx_bit_i),
    .last_i    (rx_last_i),
    .byte_stb_o(rx_stb),
    .byte_o    (rx_byte),
    .byte_idx_o(rx_idx),
    .end_o     (rx_end),
    .count_o   (rx_count),
    .partial_o (rx_partial)
  );

  // sequencing and reply watchdog
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ENG_IDLE;
      tcnt_q  <= '0;
    end else begin
      unique case (state_q)
        ENG_IDLE: if (start) state_q <= ENG_TX;
        ENG_TX:   if (ser_done) state_q <= ENG_WAIT;
        ENG_WAIT: if (rx_end || timeout_hit) state_q <= ENG_IDLE;
        default:  state_q <= ENG_IDLE;
      endcase
      if (state_q != ENG_WAIT || rx_valid_i) tcnt_q <= '0;
      else if (tick)                         tcnt_q <= tcnt_q + 1'b1;
    end
  end

  // control and status
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q   <= 1'b0;
      to_err_q <= 1'b0;
      rx_err_q <= 1'b0;
      fast_q   <= 1'b0;
      tolong_q <= 1'b0;
      size_q   <= '0;
      div_q    <= '0;
    end else if (ctrl_wr) begin
      if (wdata_i[BIT_DONE])  done_q   <= 1'b0;
      if (wdata_i[BIT_TOERR]) to_err_q <= 1'b0;
      if (wdata_i[BIT_RXERR] && !reject) rx_err_q <= 1'b0;
      if (reject)             rx_err_q <= 1'b1;
      fast_q   <= wdata_i[BIT_FAST];
      tolong_q <= wdata_i[BIT_TOLONG];
      size_q   <= req_size;
      div_q    <= wdata_i[DIV_W-1:0];
    end else if (state_q == ENG_WAIT) begin
      if (rx_end) begin
        done_q <= 1'b1;
        size_q <= rx_count;
        if (reply_bad) rx_err_q <= 1'b1;
      end else if (timeout_hit) begin
        done_q   <= 1'b1;
        to_err_q <= 1'b1;
      end
    end
  end

  // byte buffer, big-endian inside each word
  for (genvar b = 0; b < MAX_BYTES; b++) begin : g_byte
    localparam int unsigned WORD = b / 4;
    localparam int unsigned MSB  = 31 - 8 * (b % 4);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        buf_q[b] <= '0;
      else if (data_wr && addr_i == ADDR_W'(WORD + 1))
        buf_q[b] <= wdata_i[MSB -: 8];
      else if (rx_stb && rx_idx == IDX_W'(b))
        buf_q[b] <= rx_byte;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == '0) begin
      rdata_o[BIT_BUSY]           = busy;
      rdata_o[BIT_DONE]           = done_q;
      rdata_o[BIT_TOERR]          = to_err_q;
      rdata_o[BIT_RXERR]          = rx_err_q;
      rdata_o[BIT_FAST]           = fast_q;
      rdata_o[BIT_TOLONG]         = tolong_q;
      rdata_o[SIZE_LSB +: SIZE_W] = size_q;
      rdata_o[DIV_W-1:0]          = div_q;
    end else begin
      for (int w = 0; w < DATA_WORDS; w++)
        if (addr_i == ADDR_W'(w + 1))
          rdata_o = {buf_q[4*w], buf_q[4*w+1], buf_q[4*w+2], buf_q[4*w+3]};
    end
  end
endmodule

// File: rtl/aux_xact_checker.sv
module aux_xact_checker
  import aux_xact_pkg::*;
#(
  parameter int unsigned DIV_W = 11
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_i,
  input logic              done_i,
  input logic              to_err_i,
  input logic [SIZE_W-1:0] size_i,
  input logic [DIV_W+1:0]  cfg_i,
  input logic              tx_oe_i,
  input logic              tx_stb_i
);
  assert_oe_only_busy_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_oe_i |-> busy_i);

  assert_stb_while_driving_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_stb_i |-> tx_oe_i);

  assert_done_ends_busy_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_i) |-> $fell(busy_i));

  assert_timeout_with_done_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(to_err_i) |-> done_i);

  assert_size_held_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> (!busy_i || $stable(size_i)));

  assert_cfg_locked_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> $stable(cfg_i));
endmodule

bind aux_xact_engine aux_xact_checker #(.DIV_W(DIV_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .busy_i  (busy),
  .done_i  (done_q),
  .to_err_i(to_err_q),
  .size_i  (size_q),
  .cfg_i   ({fast_q, tolong_q, div_q}),
  .tx_oe_i (tx_oe_o),
  .tx_stb_i(tx_stb_o)
);

// File: tb/aux_xact_engine_test.sv
module aux_xact_engine_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  addr_i = '0;
  logic        we_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        tx_bit_o, tx_oe_o, tx_stb_o;
  logic        rx_valid_i = 1'b0, rx_bit_i = 1'b0, rx_last_i = 1'b0;

  always #5 clk = ~clk;

  aux_xact_engine uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr_i), .we_i(we_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .tx_bit_o(tx_bit_o), .tx_oe_o(tx_oe_o), .tx_stb_o(tx_stb_o),
    .rx_valid_i(rx_valid_i), .rx_bit_i(rx_bit_i), .rx_last_i(rx_last_i)
  );

  int n_chk = 0, n_err = 0;
  bit finished = 0;
  logic [7:0] exp_buf [20];
  logic       txb [256];
  longint     stamp [256];
  int         nbits = 0;
  longint     cyc = 0;

  always @(negedge clk) begin
    cyc++;
    if (tx_stb_o && nbits < 256) begin
      txb[nbits] = tx_bit_o;
      stamp[nbits] = cyc;
      nbits++;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk); addr_i = 3'(a); wdata_i = d; we_i = 1'b1;
    @(negedge clk); we_i = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] v);
    @(negedge clk); addr_i = 3'(a); #1; v = rdata_o;
  endtask

  function automatic logic [31:0] ctrl_word(bit go, bit fast, bit tolong, int size, int div);
    return {go, 3'b111, fast, tolong, 1'b0, 5'(size), 9'b0, 11'(div)};
  endfunction

  function automatic logic [31:0] exp_word(int w);
    return {exp_buf[4*w], exp_buf[4*w+1], exp_buf[4*w+2], exp_buf[4*w+3]};
  endfunction

  task automatic load_buf();
    for (int w = 0; w < 5; w++) begin
      logic [31:0] d;
      d = $urandom;
      wr(w + 1, d);
      for (int k = 0; k < 4; k++) exp_buf[4*w+k] = d[31-8*k -: 8];
    end
  endtask

  task automatic wait_tx();
    int g;
    g = 0;
    while (tx_oe_o && g < 20000) begin @(negedge clk); g++; end
  endtask

  task automatic wait_idle(output int cycles);
    logic [31:0] v;
    cycles = 0;
    rd(0, v);
    while (v[31] && cycles < 30000) begin rd(0, v); cycles++; end
  endtask

  task automatic check_tx(input bit fast, input int n_send, input int div);
    int pre, amb, bad_sync, bad_data, bad_gap, sp;
    pre = fast ? 10 : 16;
    amb = fast ? 8 : 16;
    sp  = (div == 0) ? 1 : div;
    bad_sync = 0; bad_data = 0; bad_gap = 0;
    chk(nbits == pre + amb + 8 * n_send, "R3 bit count", 32'(nbits), 32'(pre + amb + 8 * n_send));
    for (int i = 0; i < pre + amb && i < nbits; i++)
      if (txb[i] != (i >= pre)) bad_sync++;
    chk(bad_sync == 0, "R3 sync pattern", 32'(bad_sync), 0);
    for (int i = pre + amb; i < nbits; i++) begin
      int j;
      j = i - pre - amb;
      if (j / 8 < 20 && txb[i] != exp_buf[j / 8][7 - j % 8]) bad_data++;
    end
    chk(bad_data == 0, "R4 request bytes", 32'(bad_data), 0);
    for (int i = 1; i < nbits; i++)
      if (stamp[i] - stamp[i-1] != longint'(sp)) bad_gap++;
    chk(bad_gap == 0, "R5 bit spacing", 32'(bad_gap), 32'(sp));
  endtask

  task automatic send_reply(input int n_rbits);
    logic [7:0] acc;
    acc = '0;
    for (int i = 0; i < n_rbits; i++) begin
      logic b;
      b = 1'($urandom);
      @(negedge clk);
      rx_valid_i = 1'b1; rx_bit_i = b; rx_last_i = (i == n_rbits - 1);
      acc = {acc[6:0], b};
      if (i % 8 == 7 && i / 8 < 20) exp_buf[i / 8] = acc;
    end
    @(negedge clk);
    rx_valid_i = 1'b0; rx_last_i = 1'b0; rx_bit_i = 1'b0;
  endtask

  task automatic check_done(input int n_rbits, input bit fast, input int div);
    logic [31:0] v;
    int nb, c;
    bit bad;
    nb  = n_rbits / 8;
    bad = (n_rbits % 8 != 0) || nb == 0 || nb > 20;
    if (nb > 31) nb = 31;
    wait_idle(c);
    rd(0, v);
    chk(v[31:30] == 2'b01 && v[29] == 1'b0, "R6 busy clear, done set", v, 32'h4000_0000);
    chk(v[24:20] == 5'(nb), "R6 reply count", 32'(v[24:20]), 32'(nb));
    chk(v[28] == bad, bad ? "R8 receive error" : "R6 no receive error", 32'(v[28]), 32'(bad));
    chk(v[27] == fast && v[10:0] == 11'(div), "R11 config kept", v, ctrl_word(0, fast, 0, nb, div));
    for (int w = 0; w < 5; w++) begin
      logic [31:0] d;
      rd(w + 1, d);
      chk(d == exp_word(w), "R7 buffer after reply", d, exp_word(w));
    end
  endtask

  task automatic run_xact(input int n_send, input bit fast, input int div, input int n_rbits);
    logic [31:0] v;
    load_buf();
    nbits = 0;
    wr(0, ctrl_word(1, fast, 0, n_send, div));
    rd(0, v);
    chk(v[31] == 1'b1, "R2 busy after start", v, 32'h8000_0000);
    wait_tx();
    check_tx(fast, n_send, div);
    send_reply(n_rbits);
    check_done(n_rbits, fast, div);
  endtask

  task automatic run_timeout(input bit tolong, input int div);
    logic [31:0] v;
    int c, lim, exp_c, tol;
    lim = tolong ? 1200 : 800;
    exp_c = lim * ((div == 0) ? 1 : div);
    tol = 2 * div + 6;
    load_buf();
    nbits = 0;
    wr(0, ctrl_word(1, 0, tolong, 3, div));
    wait_tx();
    chk(tx_oe_o == 1'b0, "R13 line released", 32'(tx_oe_o), 0);
    wait_idle(c);
    chk(c >= exp_c - tol && c <= exp_c + tol, "R9 timeout length", 32'(c), 32'(exp_c));
    rd(0, v);
    chk(v[31:29] == 3'b011, "R9 timeout flags", v, 32'h6000_0000);
  endtask

  initial begin
    logic [31:0] v;
    int c;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rd(0, v);
    chk(v == 32'h0, "R1 control reset", v, 0);
    rd(3, v);
    chk(v == 32'h0, "R1 data reset", v, 0);
    chk({tx_oe_o, tx_stb_o, tx_bit_o} == 3'b0, "R1 line idle", 32'({tx_oe_o, tx_stb_o, tx_bit_o}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    rd(0, v);
    chk(v == 32'h0, "R1 control after release", v, 0);

    // random exchanges with legal replies
    for (int t = 0; t < 6; t++)
      run_xact(1 + $urandom % 20, 1'($urandom), $urandom % 4, 8 * (1 + $urandom % 20));

    // full-size request, normal and fast sync, divider 0
    run_xact(20, 0, 0, 160);
    run_xact(20, 1, 3, 16);

    // illegal replies
    run_xact(4, 0, 1, 8 * 21);
    run_xact(2, 1, 1, 3);
    run_xact(2, 0, 2, 12);

    // busy-time writes ignored
    load_buf();
    nbits = 0;
    wr(0, ctrl_word(1, 0, 0, 2, 1));
    wr(5, 32'hDEAD_BEEF);
    wr(0, ctrl_word(1, 1, 1, 7, 9));
    wait_tx();
    check_tx(0, 2, 1);
    send_reply(32);
    check_done(32, 0, 1);
    rd(5, v);
    chk(v == exp_word(4), "R11 data write ignored", v, exp_word(4));

    // timeouts
    run_timeout(0, 1);
    run_timeout(1, 2);

    // W1C: clear done only, then timeout error
    wr(0, 32'h4000_0001);
    rd(0, v);
    chk(v[30] == 1'b0 && v[29] == 1'b1, "R10 clear done only", v, 32'h2000_0001);
    wr(0, 32'h2000_0001);
    rd(0, v);
    chk(v[30:28] == 3'b000, "R10 clear timeout flag", v, 32'h0000_0001);

    // rejected request sizes
    wr(0, ctrl_word(1, 0, 0, 0, 1));
    rd(0, v);
    chk(v[31] == 1'b0 && v[28] == 1'b1 && !tx_oe_o, "R12 size 0 rejected", v, 32'h1000_0001);
    wr(0, 32'h1000_0001);
    wr(0, ctrl_word(1, 0, 0, 21, 1));
    rd(0, v);
    chk(v[31] == 1'b0 && v[28] == 1'b1 && !tx_oe_o, "R12 size 21 rejected", v, 32'h1150_0001);
    repeat (10) @(negedge clk);
    chk(nbits == 0 || tx_oe_o == 1'b0, "R12 line stays idle", 32'(tx_oe_o), 0);
    wr(0, 32'h1000_0001);
    rd(0, v);
    chk(v[28] == 1'b0, "R10 clear receive error", v, 32'h0000_0001);

    c = 0;
    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule